// File: doc/BRIEF.md
# Last-Target Indirect Branch Predictor

This block predicts where an indirect branch will jump by recalling the target that was last recorded in a direct-mapped table slot, and reports whether that recollection was wrong. Each accepted request carries a branch instruction address and the target the branch actually resolved to. The block picks a table slot from a window of address bits placed above a configurable number of always-zero low bits. It compares the stored target with the actual one and, one cycle later, raises a registered mispredict flag next to a response strobe. In the same cycle it overwrites the slot with the actual target, whether or not the prediction was correct.

The table carries no tags and no valid bits. Branches whose addresses share the index bits share one slot and evict each other without notice. A slot that has never been written holds zero, and zero counts as a genuine prediction. After reset the table is cleared one slot per cycle. A ready output stays low until that clear is complete, and requests presented while ready is low are dropped.

Top module: `lastgt_pred`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ready`, `resp_valid` and `resp_mispredict` are all 0.
- R2: `ready` rises exactly 2^IDX_W clock edges after reset is released, one slot cleared per edge, and then stays high until the next reset.
- R3: A request sampled with `req_valid` = 1 and `ready` = 1 produces `resp_valid` = 1 on the following cycle. In every other cycle `resp_valid` is 0.
- R4: A request presented while `ready` is 0 gives no response and does not change any table slot.
- R5: The slot index is address bits [LOW_ZERO+IDX_W-1 : LOW_ZERO]. Address bits below and above that window do not affect which slot is used.
- R6: `resp_mispredict` is 1 exactly when the slot's stored target differs from `req_target`. The stored value compared is the one from before this request's write.
- R7: Every accepted request writes `req_target` into its slot, whether the prediction was right or wrong.
- R8: After the clear, every slot holds zero, so a first request with target 0 is reported as correctly predicted.
- R9: Two addresses with equal index bits share one slot, and each overwrites the target left by the other.
- R10: A request in the cycle directly after a write to the same slot compares against the value that write stored.
- R11: `resp_mispredict` is 0 in any cycle where `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Branch instruction address |
| req_target | input | TGT_W | Resolved branch target |
| ready | output | 1 | High once the table clear has finished |
| resp_valid | output | 1 | Registered response strobe |
| resp_mispredict | output | 1 | Registered mispredict flag, valid with resp_valid |

## Verification
Two functions meet in one cycle: the lookup that forms the prediction and the overwrite of the same slot. They meet again across back-to-back cycles, when the next request reads a slot written one edge earlier. The bench provokes both by issuing requests on consecutive cycles to one slot and to aliasing addresses, with targets that alternately match and differ. A reference table in the scoreboard computes, in issue order, the flag each request should produce from the value stored before its own write. Each flag is judged against the response that appears one cycle after its request.

// File: rtl/lt_pkg.sv
// Package: shared types and helpers for the last-target predictor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lt_pkg;

    // Phase of the post-reset table initialisation.
    typedef enum logic {
        PH_CLEAR = 1'b0,
        PH_RUN   = 1'b1
    } lt_phase_e;

    // Number of table slots for a given index width.
    function automatic int unsigned lt_depth(input int unsigned idx_w);
        return 32'd1 << idx_w;
    endfunction

endpackage

// File: rtl/lt_index.sv
// Module: lt_index
// Extracts the table slot index from an instruction address. Address bits
// below LOW_ZERO are assumed always zero and skipped; the IDX_W bits above
// them form the index. Bits above the window are deliberately ignored.
// Assumes ADDR_W >= LOW_ZERO + IDX_W.
module lt_index #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LOW_ZERO = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned TOP_BIT = LOW_ZERO + IDX_W - 1;

    generate
        if (LOW_ZERO == 0) begin : g_noshift
            // Index taken straight from the bottom of the address.
            always_comb idx = addr[IDX_W-1:0];
        end else begin : g_shift
            // Index taken from the window above the always-zero bits.
            always_comb idx = addr[TOP_BIT:LOW_ZERO];
        end
    endgenerate

    // Bits outside the window are intentionally left unused.
    logic unused_addr_bits;
    assign unused_addr_bits = ^addr;

endmodule

// File: rtl/lt_clear_seq.sv
// Module: lt_clear_seq
// Walks every table slot once after reset, issuing one zero write per
// cycle, then raises ready and stays idle until the next reset.
// Assumes a synchronous active-low reset held for at least one edge.
module lt_clear_seq
    import lt_pkg::*;
#(
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx,
    output logic             ready
);

    localparam int unsigned            DEPTH = lt_depth(IDX_W);
    localparam logic [IDX_W-1:0]       LAST  = IDX_W'(DEPTH - 1);

    lt_phase_e phase_q;
    logic [IDX_W-1:0] ptr_q;

    // Advance the clear pointer and leave the clear phase after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CLEAR;
            ptr_q   <= '0;
        end else if (phase_q == PH_CLEAR) begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == LAST) begin
                phase_q <= PH_RUN;
            end
        end
    end

    // Drive the zero-write port while clearing.
    always_comb begin
        clr_we  = (phase_q == PH_CLEAR) && rst_n;
        clr_idx = ptr_q;
        ready   = (phase_q == PH_RUN);
    end

endmodule

// File: rtl/lt_table.sv
// Module: lt_table
// Direct-mapped target storage with one asynchronous read port and one
// synchronous write port. A read in the cycle after a write returns the
// new value. The array carries no reset; the clear sequencer initialises it.
module lt_table #(
    parameter int unsigned IDX_W = 9,
    parameter int unsigned TGT_W = 32
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TGT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TGT_W-1:0] wr_data
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [TGT_W-1:0] mem_q [DEPTH];

    // Store the write data into the addressed slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Present the addressed slot on the read port.
    always_comb rd_data = mem_q[rd_idx];

endmodule

// File: rtl/lt_resp.sv
// Module: lt_resp
// Registers the response strobe and the mispredict flag. The flag is
// forced low whenever no request was accepted.
module lt_resp #(
    parameter int unsigned TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [TGT_W-1:0] stored,
    input  logic [TGT_W-1:0] actual,
    output logic             resp_valid,
    output logic             resp_mispredict
);

    logic differ;

    // Detect any difference between the recorded and the resolved target.
    always_comb differ = (stored != actual);

    // Capture the outcome of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid      <= 1'b0;
            resp_mispredict <= 1'b0;
        end else begin
            resp_valid      <= fire;
            resp_mispredict <= fire && differ;
        end
    end

endmodule

// File: rtl/lastgt_pred.sv
// Module: lastgt_pred (top)
// Untagged last-target indirect branch predictor. Each accepted request
// looks up one slot, flags a mispredict if the stored target differs from
// the resolved one, and overwrites that slot with the resolved target.
// Requests are accepted only while ready is high.
module lastgt_pred #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned TGT_W    = 32,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LOW_ZERO = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TGT_W-1:0]  req_target,
    output logic              ready,
    output logic              resp_valid,
    output logic              resp_mispredict
);

    logic [IDX_W-1:0] req_idx;
    logic [IDX_W-1:0] clr_idx;
    logic             clr_we;
    logic             fire;
    logic [TGT_W-1:0] stored;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [TGT_W-1:0] wr_data;

    lt_index #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .LOW_ZERO(LOW_ZERO)
    ) idx_i (
        .addr(req_addr),
        .idx (req_idx)
    );

    lt_clear_seq #(
        .IDX_W(IDX_W)
    ) clr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_we (clr_we),
        .clr_idx(clr_idx),
        .ready  (ready)
    );

    // Accept a request only once the clear has finished.
    always_comb fire = req_valid && ready;

    // Share the single write port between the clear and request updates.
    always_comb begin
        if (clr_we) begin
            wr_en   = 1'b1;
            wr_idx  = clr_idx;
            wr_data = '0;
        end else begin
            wr_en   = fire;
            wr_idx  = req_idx;
            wr_data = req_target;
        end
    end

    lt_table #(
        .IDX_W(IDX_W),
        .TGT_W(TGT_W)
    ) tbl_i (
        .clk    (clk),
        .rd_idx (req_idx),
        .rd_data(stored),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

    lt_resp #(
        .TGT_W(TGT_W)
    ) resp_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (fire),
        .stored         (stored),
        .actual         (req_target),
        .resp_valid     (resp_valid),
        .resp_mispredict(resp_mispredict)
    );

endmodule

// File: rtl/lastgt_pred_chk.sv
// Module: lastgt_pred_chk
// Protocol and timing properties of lastgt_pred, observed at its ports.
// Bound into every instance of the top module.
module lastgt_pred_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TGT_W  = 32,
    parameter int unsigned IDX_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [TGT_W-1:0]  req_target,
    input logic              ready,
    input logic              resp_valid,
    input logic              resp_mispredict
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic             fire;
    logic [IDX_W+1:0] since_rst_q;

    always_comb fire = req_valid && ready;

    // Count edges since reset release, saturating just past the clear length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q <= (IDX_W+2)'(DEPTH)) begin
            since_rst_q <= since_rst_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ready && !resp_valid && !resp_mispredict)); // R1

    AST_NOT_READY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < (IDX_W+2)'(DEPTH)) |-> !ready); // R2

    AST_READY_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= (IDX_W+2)'(DEPTH)) |-> ready); // R2

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R2

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> resp_valid); // R3

    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !resp_valid); // R4

    AST_REPEAT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(fire) && (req_addr == $past(req_addr))
         && (req_target == $past(req_target))) |=> !resp_mispredict); // R10

    AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_mispredict); // R11

endmodule

bind lastgt_pred lastgt_pred_chk #(
    .ADDR_W(ADDR_W),
    .TGT_W (TGT_W),
    .IDX_W (IDX_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_target     (req_target),
    .ready          (ready),
    .resp_valid     (resp_valid),
    .resp_mispredict(resp_mispredict)
);

// File: tb/lastgt_pred_tb_top.sv
// Scoreboard bench for lastgt_pred: the driver pushes the expected flag per
// request, computed from a reference table, and the monitor compares.
module lastgt_pred_tb_top;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned TGT_W  = 32;
    localparam int unsigned IDX_W  = 9;
    localparam int unsigned LZ     = 2;
    localparam int unsigned DEPTH  = 1 << IDX_W;

    typedef struct {
        logic  misp;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TGT_W-1:0]  req_target = '0;
    logic              ready;
    logic              resp_valid;
    logic              resp_mispredict;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    logic [TGT_W-1:0] ref_tbl [DEPTH];

    always #2 clk = ~clk;

    lastgt_pred #(
        .ADDR_W  (ADDR_W),
        .TGT_W   (TGT_W),
        .IDX_W   (IDX_W),
        .LOW_ZERO(LZ)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_target     (req_target),
        .ready          (ready),
        .resp_valid     (resp_valid),
        .resp_mispredict(resp_mispredict)
    );

    function automatic int unsigned slot_of(input logic [ADDR_W-1:0] a);
        return int'((a >> LZ) & (DEPTH - 1));
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request for one cycle and record its expected flag.
    task automatic issue(input logic [ADDR_W-1:0] a, input logic [TGT_W-1:0] t,
                         input string tag);
        exp_t e;
        int unsigned s;
        s = slot_of(a);
        e.misp = (ref_tbl[s] != t);
        e.tag  = tag;
        exp_q.push_back(e);
        ref_tbl[s] = t;
        @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = a;
        req_target = t;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each response with the head of the queue.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (!resp_valid && resp_mispredict)
                check(1'b0, "R11 flag without strobe", 64'(resp_mispredict), 64'd0);
            if (resp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R4 unexpected response", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(resp_mispredict == e.misp, e.tag,
                          64'(resp_mispredict), 64'(e.misp));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < int'(DEPTH); i++) ref_tbl[i] = '0;

        // R1: outputs quiet while reset is held.
        repeat (3) @(negedge clk);
        check(!ready && !resp_valid && !resp_mispredict, "R1 reset outputs",
              {61'd0, ready, resp_valid, resp_mispredict}, 64'd0);

        // Release reset and count edges until ready (R2), probing R4 meanwhile.
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!ready && cyc < 2 * int'(DEPTH)) begin
            @(posedge clk);
            #1;
            cyc++;
            if (cyc == 1)
                check(!ready && !resp_valid, "R1 first cycle after reset",
                      {62'd0, ready, resp_valid}, 64'd0);
            if (cyc == 20) begin
                // R4: request to slot 0 (already cleared) while not ready.
                @(negedge clk);
                req_valid  = 1'b1;
                req_addr   = 32'h0000_0000;
                req_target = 32'hDEAD_BEEF;
                @(posedge clk);
                #1;
                cyc++;
                req_valid = 1'b0;
                @(posedge clk);
                #1;
                cyc++;
                check(!resp_valid, "R4 no response while not ready",
                      64'(resp_valid), 64'd0);
            end
        end
        check(cyc == int'(DEPTH), "R2 clear length", 64'(cyc), 64'(DEPTH));

        // R4: the dropped request left slot 0 at zero.
        issue(32'h0000_0000, 32'h0, "R4 slot untouched by dropped request");
        // R8: fresh slot predicts zero.
        issue(32'h0000_0040, 32'h0, "R8 zero is a real prediction");
        issue(32'h0000_0080, 32'h1234_5678, "R6 mismatch on fresh slot");
        idle(1);
        check(ready, "R2 ready stays high", 64'(ready), 64'd1);

        // R7 + R10: back-to-back same slot, matching then differing.
        issue(32'h0000_0100, 32'hAAAA_0000, "R6 first write");
        issue(32'h0000_0100, 32'hAAAA_0000, "R10 next cycle sees write");
        issue(32'h0000_0100, 32'hBBBB_0000, "R7 overwrite after correct");
        issue(32'h0000_0100, 32'hCCCC_0000, "R7 overwrite after wrong");
        issue(32'h0000_0100, 32'hCCCC_0000, "R10 sees wrong-path write");

        // R5: bits below and above the index window select the same slot.
        issue(32'h0000_0203, 32'h5555_0000, "R5 low bits ignored, write");
        issue(32'h0010_0200, 32'h5555_0000, "R5 high bits ignored");
        issue(32'h0000_0204, 32'h5555_0000, "R5 adjacent slot distinct");

        // R9: aliasing addresses (differ only at bit LZ+IDX_W) evict each other.
        issue(32'h0000_0300, 32'h1111_1111, "R9 alias A write");
        issue(32'h0000_0B00, 32'h2222_2222, "R9 alias B sees A");
        issue(32'h0000_0300, 32'h1111_1111, "R9 alias A evicted by B");
        issue(32'h0000_0B00, 32'h1111_1111, "R9 alias B sees A again");
        idle(2);

        // Sparse traffic with gaps.
        for (int k = 0; k < 24; k++) begin
            issue(32'(k * 36), 32'(k % 5), "R6 mixed pattern");
            if (k % 3 == 0) idle(1);
        end
        idle(4);
        check(exp_q.size() == 0, "R3 every request answered",
              64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule